// File: doc/BRIEF.md
# Interrupt Destination Resolver and Dispatcher

This block takes one interrupt delivery request and decides which processor-side interrupt controllers receive it. A request carries an 8-bit destination, a destination-mode flag (physical or logical), a 3-bit delivery mode, a vector and a trigger level. Each of the NUM_TGT targets (default 8) reports whether it is present, together with an 8-bit physical ID and an 8-bit logical ID. The block combines these into a target set.

After resolving the set, the block dispatches the interrupt as one-cycle inject strobes. Each strobe names one target index and carries the vector and trigger level. In fixed mode every target in the set is served, lowest index first. In lowest-priority mode exactly one target is served, and a rotating pointer picks it. Requests with an empty set and requests with any other delivery mode are dropped. A new request is taken only while the block is idle.

Top module: `irq_route_dispatch`

## Requirements
- R1: In physical mode (req_logical=0), destination 0xFF selects every target whose present flag is set.
- R2: In physical mode with any destination other than 0xFF, only the lowest-indexed present target whose physical ID equals the destination is selected. At most one target is selected.
- R3: In logical mode (req_logical=1), destination 0x00 selects no target.
- R4: In logical mode with a nonzero destination, every present target whose logical ID has a nonzero bitwise AND with the destination is selected.
- R5: A request whose target set is empty is dropped. Busy stays low and no strobe is issued.
- R6: Delivery mode 3'b000 (fixed) issues one strobe per target in the set, on consecutive cycles and in ascending index order. The first strobe comes in the cycle after acceptance.
- R7: Delivery mode 3'b001 (lowest priority) issues exactly one strobe. The chosen target is the first set member at or after a rotating pointer, wrapping around. The pointer then moves to one past the chosen index, modulo NUM_TGT.
- R8: Delivery modes 3'b010 through 3'b111 are dropped. Busy stays low and no strobe is issued.
- R9: Busy is high from the cycle after acceptance until the last strobe of the request. A request presented while busy is ignored.
- R10: Every strobe carries the vector and the trigger level of the request it belongs to.
- R11: After reset, busy and the inject strobe are low and the rotating pointer is at target 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_dest | input | DEST_W | Destination field |
| req_logical | input | 1 | 1 = logical destination, 0 = physical |
| req_dmode | input | 3 | Delivery mode: 000 fixed, 001 lowest priority |
| req_vector | input | VEC_W | Interrupt vector |
| req_level | input | 1 | Trigger level (1 = level, 0 = edge) |
| tgt_present | input | NUM_TGT | Per-target present flag |
| tgt_phys_id | input | NUM_TGT*DEST_W | Physical IDs, target i at bits [i*DEST_W +: DEST_W] |
| tgt_logic_id | input | NUM_TGT*DEST_W | Logical IDs, same packing |
| busy | output | 1 | Dispatch in progress |
| inj_valid | output | 1 | One-cycle inject strobe |
| inj_target | output | IDX_W | Target index of the strobe |
| inj_vector | output | VEC_W | Vector carried by the strobe |
| inj_level | output | 1 | Trigger level carried by the strobe |

## Verification
The hardest situation to reach is the wrap of the rotating pointer. The pointer is not visible at the ports, so it can only be steered through a sequence of lowest-priority requests. The stimulus issues several broadcast lowest-priority requests to walk the pointer up the index range. It then sends a logical request whose set holds one high and one low target, so the next pick must wrap back to the low one. A second request is also presented in the middle of a fixed broadcast, which shows it is ignored while busy.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   typedef logic [2:0] dmode_t;
   localparam dmode_t DM_FIXED  = 3'b000;
   localparam dmode_t DM_LOWEST = 3'b001;
endpackage

// File: rtl/irq_lowest_bit.sv
module irq_lowest_bit #(
   parameter int NUM   = 8,
   localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
   input  logic [NUM-1:0]   vec,
   output logic [NUM-1:0]   onehot,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      onehot = vec & (~vec + NUM'(1));
      idx    = '0;
      for (int i = NUM - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_dest_resolve.sv
module irq_dest_resolve #(
   parameter int NUM_TGT = 8,
   parameter int DEST_W  = 8
) (
   input  logic [DEST_W-1:0]         dest,
   input  logic                      logical,
   input  logic [NUM_TGT-1:0]        present,
   input  logic [NUM_TGT*DEST_W-1:0] phys_id,
   input  logic [NUM_TGT*DEST_W-1:0] logic_id,
   output logic [NUM_TGT-1:0]        tgt_set
);
   localparam logic [DEST_W-1:0] BCAST = {DEST_W{1'b1}};

   logic [NUM_TGT-1:0] phys_eq, logic_hit, phys_first;

   for (genvar g = 0; g < NUM_TGT; g++) begin : g_match
      assign phys_eq[g]   = present[g] && (phys_id[g*DEST_W +: DEST_W] == dest);
      assign logic_hit[g] = present[g] && |(logic_id[g*DEST_W +: DEST_W] & dest);
   end

   // isolate the lowest matching physical target
   assign phys_first = phys_eq & (~phys_eq + NUM_TGT'(1));

   always_comb begin
      if (!logical)
         tgt_set = (dest == BCAST) ? present : phys_first;
      else
         tgt_set = (dest == '0) ? '0 : logic_hit;
   end
endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
   parameter int NUM_TGT = 8,
   localparam int IDX_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
   input  logic [NUM_TGT-1:0] cand,
   input  logic [IDX_W-1:0]   ptr,
   output logic [NUM_TGT-1:0] pick_oh,
   output logic [IDX_W-1:0]   pick_idx,
   output logic [IDX_W-1:0]   next_ptr
);
   logic [NUM_TGT-1:0] upper, up_oh, all_oh;
   logic [IDX_W-1:0]   up_idx, all_idx;

   assign upper = cand & ({NUM_TGT{1'b1}} << ptr);

   irq_lowest_bit #(.NUM(NUM_TGT)) u_up  (.vec(upper), .onehot(up_oh),  .idx(up_idx));
   irq_lowest_bit #(.NUM(NUM_TGT)) u_all (.vec(cand),  .onehot(all_oh), .idx(all_idx));

   always_comb begin
      if (|upper) begin
         pick_oh  = up_oh;
         pick_idx = up_idx;
      end else begin
         pick_oh  = all_oh;
         pick_idx = all_idx;
      end
      next_ptr = (pick_idx == IDX_W'(NUM_TGT - 1)) ? '0 : pick_idx + 1'b1;
   end
endmodule

// File: rtl/irq_route_dispatch.sv
module irq_route_dispatch
   import irq_route_pkg::*;
#(
   parameter int NUM_TGT = 8,
   parameter int DEST_W  = 8,
   parameter int VEC_W   = 8,
   localparam int IDX_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [DEST_W-1:0]         req_dest,
   input  logic                      req_logical,
   input  logic [2:0]                req_dmode,
   input  logic [VEC_W-1:0]          req_vector,
   input  logic                      req_level,
   input  logic [NUM_TGT-1:0]        tgt_present,
   input  logic [NUM_TGT*DEST_W-1:0] tgt_phys_id,
   input  logic [NUM_TGT*DEST_W-1:0] tgt_logic_id,
   output logic                      busy,
   output logic                      inj_valid,
   output logic [IDX_W-1:0]          inj_target,
   output logic [VEC_W-1:0]          inj_vector,
   output logic                      inj_level
);
   if (NUM_TGT < 2 || NUM_TGT > 64) begin : g_bad_num
      $error("NUM_TGT must lie in 2..64");
   end
   if (DEST_W < 2) begin : g_bad_dest
      $error("DEST_W must be at least 2");
   end
   if (VEC_W < 1) begin : g_bad_vec
      $error("VEC_W must be at least 1");
   end

   logic [NUM_TGT-1:0] res_set, rr_oh, pend_q, cur_oh, load_set;
   logic [IDX_W-1:0]   rr_ptr_q, rr_idx, rr_next, cur_idx;
   logic [VEC_W-1:0]   vec_q;
   logic               lvl_q, accept, mode_ok, is_lowest;

   irq_dest_resolve #(.NUM_TGT(NUM_TGT), .DEST_W(DEST_W)) u_res (
      .dest(req_dest), .logical(req_logical), .present(tgt_present),
      .phys_id(tgt_phys_id), .logic_id(tgt_logic_id), .tgt_set(res_set));

   irq_rr_pick #(.NUM_TGT(NUM_TGT)) u_rr (
      .cand(res_set), .ptr(rr_ptr_q), .pick_oh(rr_oh),
      .pick_idx(rr_idx), .next_ptr(rr_next));

   irq_lowest_bit #(.NUM(NUM_TGT)) u_cur (.vec(pend_q), .onehot(cur_oh), .idx(cur_idx));

   assign is_lowest = (req_dmode == DM_LOWEST);
   assign mode_ok   = (req_dmode == DM_FIXED) || is_lowest;
   assign accept    = req_valid && !busy && mode_ok && (|res_set);
   assign load_set  = is_lowest ? rr_oh : res_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         vec_q    <= '0;
         lvl_q    <= 1'b0;
         rr_ptr_q <= '0;
      end else if (accept) begin
         pend_q <= load_set;
         vec_q  <= req_vector;
         lvl_q  <= req_level;
         if (is_lowest) rr_ptr_q <= rr_next;
      end else if (busy) begin
         pend_q <= pend_q & ~cur_oh;
      end
   end

   assign busy       = |pend_q;
   assign inj_valid  = busy;
   assign inj_target = cur_idx;
   assign inj_vector = vec_q;
   assign inj_level  = lvl_q;
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
   import irq_route_pkg::*;
#(
   parameter int NUM_TGT = 8,
   parameter int DEST_W  = 8,
   parameter int VEC_W   = 8,
   localparam int IDX_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic [DEST_W-1:0]  req_dest,
   input logic               req_logical,
   input logic [2:0]         req_dmode,
   input logic [NUM_TGT-1:0] tgt_present,
   input logic [NUM_TGT-1:0] res_set,
   input logic               busy,
   input logic               inj_valid,
   input logic [IDX_W-1:0]   inj_target,
   input logic [VEC_W-1:0]   inj_vector,
   input logic               inj_level
);
   AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_logical && req_dest == {DEST_W{1'b1}}) |-> res_set == tgt_present); // R1
   AST_PHYS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_logical && req_dest != {DEST_W{1'b1}}) |-> $onehot0(res_set)); // R2
   AST_LOGIC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (req_logical && req_dest == '0) |-> res_set == '0); // R3
   AST_EMPTY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && res_set == '0) |=> !busy); // R5
   AST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_valid && $past(inj_valid)) |-> inj_target > $past(inj_target)); // R6
   AST_LOWEST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_dmode == DM_LOWEST && res_set != '0)
      |=> inj_valid ##1 !busy); // R7
   AST_MODE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && req_dmode > DM_LOWEST) |=> !busy); // R8
   AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_valid && $past(inj_valid)) |-> ($stable(inj_vector) && $stable(inj_level))); // R10
endmodule

bind irq_route_dispatch irq_route_chk #(
   .NUM_TGT(NUM_TGT), .DEST_W(DEST_W), .VEC_W(VEC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
   .req_logical(req_logical), .req_dmode(req_dmode), .tgt_present(tgt_present),
   .res_set(res_set), .busy(busy), .inj_valid(inj_valid), .inj_target(inj_target),
   .inj_vector(inj_vector), .inj_level(inj_level));

// File: tb/sim_irq_route_dispatch.sv
module sim_irq_route_dispatch;
   localparam int N  = 8;
   localparam int W  = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic [W-1:0]   req_dest = '0;
   logic           req_logical = 1'b0;
   logic [2:0]     req_dmode = '0;
   logic [7:0]     req_vector = '0;
   logic           req_level = 1'b0;
   logic [N-1:0]   tgt_present = '0;
   logic [N*W-1:0] tgt_phys_id = '0;
   logic [N*W-1:0] tgt_logic_id = '0;
   logic           busy, inj_valid, inj_level;
   logic [IW-1:0]  inj_target;
   logic [7:0]     inj_vector;

   irq_route_dispatch u0 (.*);

   typedef struct {
      int    tgt;
      int    vec;
      int    lvl;
      string req;
   } exp_t;

   exp_t       exp_q[$];
   int         checks = 0;
   int         errors = 0;
   int         rr_ptr = 0;
   int         cyc = 0;
   bit         done = 1'b0;
   logic [7:0] phys_m [N];
   logic [7:0] logi_m [N];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && inj_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected strobe target", int'(inj_target), -1);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(int'(inj_target) == e.tgt, e.req, "target", int'(inj_target), e.tgt);
            check(int'(inj_vector) == e.vec && int'(inj_level) == e.lvl, "R10",
                  "vector*2+level", int'(inj_vector) * 2 + int'(inj_level), e.vec * 2 + e.lvl);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         errors++;
         $display("FAIL R9 watchdog cycles=%0d expected below %0d", cyc, 100000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [N-1:0] model_set(input logic [7:0] dest, input logic lg);
      logic [N-1:0] s;
      bit found;
      s = '0;
      found = 1'b0;
      if (!lg) begin
         if (dest == 8'hFF) s = tgt_present;
         else
            for (int i = 0; i < N; i++)
               if (!found && tgt_present[i] && phys_m[i] == dest) begin
                  s[i] = 1'b1;
                  found = 1'b1;
               end
      end else if (dest != 8'h00) begin
         for (int i = 0; i < N; i++)
            if (tgt_present[i] && (dest & logi_m[i]) != 8'h00) s[i] = 1'b1;
      end
      return s;
   endfunction

   task automatic send(input logic [7:0] dest, input logic lg, input logic [2:0] dm,
                       input logic [7:0] vec, input logic lvl, input string tag,
                       input bit poke);
      logic [N-1:0] s;
      int nexp;
      s = model_set(dest, lg);
      nexp = 0;
      if (dm == 3'b000) begin
         for (int i = 0; i < N; i++)
            if (s[i]) begin
               exp_q.push_back('{i, int'(vec), int'(lvl), tag});
               nexp++;
            end
      end else if (dm == 3'b001 && s != '0) begin
         for (int k = 0; k < N; k++) begin
            int j;
            j = (rr_ptr + k) % N;
            if (s[j] && nexp == 0) begin
               exp_q.push_back('{j, int'(vec), int'(lvl), tag});
               nexp++;
               rr_ptr = (j + 1) % N;
            end
         end
      end
      @(negedge clk);
      req_valid = 1'b1; req_dest = dest; req_logical = lg;
      req_dmode = dm; req_vector = vec; req_level = lvl;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == (nexp > 0), (nexp > 0) ? "R9" : tag, "busy after request",
            int'(busy), int'(nexp > 0));
      if (poke && nexp > 0) begin
         // a request while busy must not add any strobe (R9)
         req_valid = 1'b1; req_dest = 8'hFF; req_logical = 1'b0;
         req_dmode = 3'b000; req_vector = 8'hEE; req_level = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
      end
      while (busy) @(negedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, tag, "strobes still missing", exp_q.size(), 0);
      check(busy == 1'b0 && inj_valid == 1'b0, tag, "idle after dispatch",
            int'(busy), 0);
   endtask

   initial begin
      tgt_present = 8'b1111_1110;
      for (int i = 0; i < N; i++) begin
         phys_m[i] = 8'h10 + 8'(i);
         logi_m[i] = 8'(1 << i);
      end
      phys_m[0] = 8'h09; phys_m[2] = 8'h09; phys_m[5] = 8'h09;
      logi_m[6] = 8'h0C;
      for (int i = 0; i < N; i++) begin
         tgt_phys_id[i*W +: W]  = phys_m[i];
         tgt_logic_id[i*W +: W] = logi_m[i];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && inj_valid == 1'b0, "R11", "reset outputs",
            int'(busy) + int'(inj_valid), 0);

      send(8'hFF, 1'b0, 3'b000, 8'h31, 1'b0, "R1", 1'b0);  // broadcast, fixed R6
      send(8'h09, 1'b0, 3'b000, 8'h42, 1'b1, "R2", 1'b0);  // duplicate ID -> target 2
      send(8'h77, 1'b0, 3'b000, 8'h43, 1'b0, "R5", 1'b0);  // no physical match
      send(8'h00, 1'b1, 3'b000, 8'h44, 1'b0, "R3", 1'b0);  // logical zero
      send(8'h0C, 1'b1, 3'b000, 8'h55, 1'b1, "R4", 1'b0);  // targets 2,3,6
      send(8'hFF, 1'b0, 3'b010, 8'h66, 1'b0, "R8", 1'b0);
      send(8'hFF, 1'b0, 3'b111, 8'h67, 1'b0, "R8", 1'b0);
      send(8'h03, 1'b1, 3'b000, 8'h68, 1'b0, "R6", 1'b0);  // target 1 only (0 absent)
      // R7: pointer starts at 0; target 0 absent so 1, then 2, 3, 4
      for (int k = 0; k < 4; k++)
         send(8'hFF, 1'b0, 3'b001, 8'h70 + 8'(k), 1'(k), "R7", 1'b0);
      send(8'h82, 1'b1, 3'b001, 8'h80, 1'b1, "R7", 1'b0);  // pointer 5 -> pick 7
      send(8'h82, 1'b1, 3'b001, 8'h81, 1'b0, "R7", 1'b0);  // wrap -> pick 1
      send(8'h00, 1'b1, 3'b001, 8'h82, 1'b0, "R3", 1'b0);  // empty, pointer kept
      send(8'h82, 1'b1, 3'b001, 8'h83, 1'b1, "R7", 1'b0);  // pointer 2 -> pick 7
      send(8'hFF, 1'b0, 3'b000, 8'h90, 1'b1, "R9", 1'b1);  // poke while busy
      send(8'hFF, 1'b0, 3'b000, 8'hA5, 1'b1, "R10", 1'b0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule